// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block produces the repeating timing frame that walks a four-input ADC multiplexer through its channels. A prescaler divides the fast core clock into a slow conversion tick. Each frame runs one to four conversions in the fixed order 0, 1, 2, 3, then one settle slot that lets the reference recover after the input change. A conversion takes two slow ticks with the short filter and three slow ticks with the long filter.

Around this frame the block issues the handshakes that the rest of the metering datapath needs:
- a compute-pass start strobe at the start of channel 0;
- a done strobe and a channel index as each conversion ends;
- a frame-sync pulse on entry to the settle slot;
- a monitor transmit window that opens with the settle slot;
- a transfer-busy flag that is raised once every programmed number of passes.

The block carries no analog path and no data. It only produces the timing.

Top module: `mux_frame_seq`

The sequencer has two named states:
- FS_SETTLE: the settle slot. This is also the reset state.
- FS_CONV: converting. A channel counter and a slot counter track the position inside this state.

The transitions all happen on a slow tick:
- *start* takes FS_SETTLE to FS_CONV. It latches the configuration and selects channel 0.
- *step* keeps FS_CONV in FS_CONV. It moves to the next slot, or to the next channel after the last slot of a conversion.
- *close* takes FS_CONV to FS_SETTLE after the last slot of the last channel.

## Requirements
- R1: While reset is held and after it is released, mux_state reads 4 (settle) and every strobe and xfer_busy read 0. The first pass_start comes exactly CK_PER_SLOW fast cycles after reset is released.
- R2: The slow tick occurs once every CK_PER_SLOW fast cycles. All state changes fall on that tick.
- R3: The number of conversions is N = div_m1 + 1. The fir_long input selects the filter: 0 is the short filter at 2 ticks per conversion, 1 is the long filter at 3 ticks per conversion. From one pass_start to the next there are (1 + N*2)*CK_PER_SLOW fast cycles with the short filter and (1 + N*3)*CK_PER_SLOW with the long filter.
- R4: mux_state holds channel c (values 0 to N-1) for one conversion time each, in rising order. It then holds 4 for exactly one slow tick.
- R5: pass_start is a one-cycle pulse in the first fast cycle of channel 0, once per frame.
- R6: As channel c finishes, conv_done pulses for one cycle and done_chan = c. This happens in the first fast cycle after that conversion, at offset (c+1)*k*CK_PER_SLOW from pass_start, where k is the ticks per conversion.
- R7: frame_sync pulses for one cycle in the first fast cycle of the settle slot.
- R8: mon_active is high for exactly MON_LEN fast cycles, starting in the first cycle of the settle slot. It is low whenever pass_start is high.
- R9: A change to div_m1 or fir_long made during a frame does not affect that frame. It takes effect from the next frame.
- R10: Let P = presamps*sum_cycles, with a product of 0 treated as 1. xfer_busy rises with the pass_start of every P-th pass counted from reset. It stays high through that frame and falls at the next pass_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast core clock |
| rst_n | input | 1 | active-low synchronous reset |
| div_m1 | input | 2 | number of conversions minus one |
| fir_long | input | 1 | 0: 2 ticks per conversion, 1: 3 ticks per conversion |
| presamps | input | PRE_W | first factor of the transfer period |
| sum_cycles | input | SUM_W | second factor of the transfer period |
| mux_state | output | 3 | current channel 0..3, or 4 for settle |
| pass_start | output | 1 | compute-pass start strobe |
| conv_done | output | 1 | conversion-complete strobe |
| done_chan | output | 2 | channel of the finished conversion |
| frame_sync | output | 1 | settle-entry pulse |
| mon_active | output | 1 | monitor transmit window |
| xfer_busy | output | 1 | periodic transfer flag |

## Verification
The bench builds the block with CK_PER_SLOW = 10, MON_LEN = 7 and 4-bit transfer factors. With these values the longest frame is 130 fast cycles, so every conversion count and both filter lengths can be measured frame by frame. The small transfer factors let the bench reach several wraps of the pass counter, including the zero-product case. The window length stays close to, but below, the settle slot, so the bench still checks that the window closes before the next pass begins.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
    typedef enum logic [0:0] {
        FS_SETTLE = 1'b0,
        FS_CONV   = 1'b1
    } fs_state_t;

    localparam int MUX_W       = 3;
    localparam int CH_W        = 2;
    localparam int SLOT_W      = 2;
    localparam logic [MUX_W-1:0] SETTLE_CODE = 3'd4;
endpackage

// File: rtl/mfs_tick_gen.sv
module mfs_tick_gen #(
    parameter int CK_PER_SLOW = 150
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CK_PER_SLOW > 1) ? $clog2(CK_PER_SLOW) : 1;
    localparam logic [CW-1:0] LAST = CW'(CK_PER_SLOW - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/mfs_frame_fsm.sv
module mfs_frame_fsm
    import mfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CH_W-1:0]   div_m1,
    input  logic              fir_long,
    output logic              pass_go,
    output logic              settle_go,
    output logic [MUX_W-1:0]  mux_state,
    output logic              pass_start,
    output logic              conv_done,
    output logic [CH_W-1:0]   done_chan,
    output logic              frame_sync
);
    fs_state_t         st, st_n;
    logic [CH_W-1:0]   chan, chan_n;
    logic [SLOT_W-1:0] slot, slot_n;
    logic [CH_W-1:0]   cfg_last;
    logic              cfg_long;
    logic              slot_last, chan_last, conv_end;

    assign slot_last = (slot == (cfg_long ? SLOT_W'(2) : SLOT_W'(1)));
    assign chan_last = (chan == cfg_last);
    assign conv_end  = tick && (st == FS_CONV) && slot_last;
    assign pass_go   = tick && (st == FS_SETTLE);
    assign settle_go = conv_end && chan_last;
    assign mux_state = (st == FS_SETTLE) ? SETTLE_CODE : {1'b0, chan};

    // next-state logic
    always_comb begin
        st_n   = st;
        chan_n = chan;
        slot_n = slot;
        if (tick) begin
            unique case (st)
                FS_SETTLE: begin            // start
                    st_n   = FS_CONV;
                    chan_n = '0;
                    slot_n = '0;
                end
                FS_CONV: begin
                    if (!slot_last) begin   // step (slot)
                        slot_n = slot + 1'b1;
                    end else if (!chan_last) begin  // step (channel)
                        slot_n = '0;
                        chan_n = chan + 1'b1;
                    end else begin          // close
                        st_n   = FS_SETTLE;
                        slot_n = '0;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= FS_SETTLE;
            chan     <= '0;
            slot     <= '0;
            cfg_last <= '0;
            cfg_long <= 1'b0;
        end else begin
            st   <= st_n;
            chan <= chan_n;
            slot <= slot_n;
            if (pass_go) begin
                cfg_last <= div_m1;
                cfg_long <= fir_long;
            end
        end
    end

    // registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_start <= 1'b0;
            conv_done  <= 1'b0;
            done_chan  <= '0;
            frame_sync <= 1'b0;
        end else begin
            pass_start <= pass_go;
            conv_done  <= conv_end;
            frame_sync <= settle_go;
            if (conv_end)
                done_chan <= chan;
        end
    end
endmodule

// File: rtl/mfs_mon_window.sv
module mfs_mon_window #(
    parameter int MON_LEN = 140
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_go,
    output logic active
);
    localparam int MW = $clog2(MON_LEN + 1);

    logic [MW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (open_go)
            remain <= MW'(MON_LEN);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);
endmodule

// File: rtl/mfs_pass_cnt.sv
module mfs_pass_cnt #(
    parameter int PRE_W = 8,
    parameter int SUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass_go,
    input  logic [PRE_W-1:0] presamps,
    input  logic [SUM_W-1:0] sum_cycles,
    output logic             busy
);
    localparam int CW = PRE_W + SUM_W;

    logic [CW-1:0] prod, goal, cnt;
    logic [CW:0]   nxt;

    assign prod = CW'(presamps) * CW'(sum_cycles);
    assign goal = (prod == '0) ? CW'(1) : prod;
    assign nxt  = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (pass_go) begin
            if (nxt >= {1'b0, goal}) begin
                cnt  <= '0;
                busy <= 1'b1;
            end else begin
                cnt  <= nxt[CW-1:0];
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mux_frame_seq.sv
module mux_frame_seq
    import mfs_pkg::*;
#(
    parameter int CK_PER_SLOW = 150,
    parameter int MON_LEN     = 140,
    parameter int PRE_W       = 8,
    parameter int SUM_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        div_m1,
    input  logic              fir_long,
    input  logic [PRE_W-1:0]  presamps,
    input  logic [SUM_W-1:0]  sum_cycles,
    output logic [2:0]        mux_state,
    output logic              pass_start,
    output logic              conv_done,
    output logic [1:0]        done_chan,
    output logic              frame_sync,
    output logic              mon_active,
    output logic              xfer_busy
);
    logic tick, pass_go, settle_go;

    mfs_tick_gen #(.CK_PER_SLOW(CK_PER_SLOW)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    mfs_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .div_m1    (div_m1),
        .fir_long  (fir_long),
        .pass_go   (pass_go),
        .settle_go (settle_go),
        .mux_state (mux_state),
        .pass_start(pass_start),
        .conv_done (conv_done),
        .done_chan (done_chan),
        .frame_sync(frame_sync)
    );

    mfs_mon_window #(.MON_LEN(MON_LEN)) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_go(settle_go),
        .active (mon_active)
    );

    mfs_pass_cnt #(.PRE_W(PRE_W), .SUM_W(SUM_W)) u_pass (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_go   (pass_go),
        .presamps  (presamps),
        .sum_cycles(sum_cycles),
        .busy      (xfer_busy)
    );
endmodule

// File: rtl/mux_frame_seq_chk.sv
module mux_frame_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mux_state,
    input logic       pass_start,
    input logic       conv_done,
    input logic       frame_sync,
    input logic       mon_active,
    input logic       xfer_busy
);
    // R5
    pass_at_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start |-> (mux_state == 3'd0));

    // R5
    pass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start |=> !pass_start);

    // R7
    sync_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> (mux_state == 3'd4 && mon_active && conv_done));

    // R8
    mon_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start |-> !mon_active);

    // R8
    mon_in_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_active |-> (mux_state == 3'd4));

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> pass_start);

    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_busy) |-> pass_start);
endmodule

bind mux_frame_seq mux_frame_seq_chk u_chk (.*);

// File: tb/mux_frame_seq_bench.sv
module mux_frame_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CKS   = 10;
    localparam int MON   = 7;
    localparam int PW    = 4;
    localparam int SW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    div_m1 = 2'd3;
    logic          fir_long = 1'b1;
    logic [PW-1:0] presamps = 4'd1;
    logic [SW-1:0] sum_cycles = 4'd1;
    logic [2:0]    mux_state;
    logic          pass_start, conv_done, frame_sync, mon_active, xfer_busy;
    logic [1:0]    done_chan;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_frame_seq #(.CK_PER_SLOW(CKS), .MON_LEN(MON), .PRE_W(PW), .SUM_W(SW)) u_mux_frame_seq (
        .clk(clk), .rst_n(rst_n), .div_m1(div_m1), .fir_long(fir_long),
        .presamps(presamps), .sum_cycles(sum_cycles), .mux_state(mux_state),
        .pass_start(pass_start), .conv_done(conv_done), .done_chan(done_chan),
        .frame_sync(frame_sync), .mon_active(mon_active), .xfer_busy(xfer_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_pass();
        do @(negedge clk); while (!pass_start);
    endtask

    // assumes the current negedge shows pass_start; ends at the next pass_start
    task automatic scan_frame(input int d, input int k, input int chg_off,
                              input logic [1:0] nd_m1, input logic nl);
        int off = 0, nd = 0, mon_n = 0, mon_first = -1, fs_off = -1;
        int conv_span = k * CKS;
        check(mux_state == 3'd0, "R4 ch0 at pass", mux_state, 0);
        forever begin
            @(negedge clk);
            off++;
            if (off == chg_off) begin
                div_m1 = nd_m1;
                fir_long = nl;
            end
            if (pass_start) break;
            if (conv_done) begin
                check(off == (nd + 1) * conv_span, "R6 done offset", off, (nd + 1) * conv_span);
                check(done_chan == nd[1:0], "R6 done_chan", done_chan, nd);
                nd++;
            end
            if (frame_sync) fs_off = off;
            if (mon_active) begin
                mon_n++;
                if (mon_first < 0) mon_first = off;
            end
            if (off % conv_span == 0 && off < d * conv_span)
                check(mux_state == 3'(off / conv_span), "R4 channel order", mux_state, off / conv_span);
            if (off == d * conv_span)
                check(mux_state == 3'd4, "R4 settle code", mux_state, 4);
        end
        check(off == (1 + d * k) * CKS, "R3 frame length", off, (1 + d * k) * CKS);
        check(nd == d, "R6 done count", nd, d);
        check(fs_off == d * conv_span, "R7 sync offset", fs_off, d * conv_span);
        check(mon_first == d * conv_span, "R8 window start", mon_first, d * conv_span);
        check(mon_n == MON, "R8 window length", mon_n, MON);
        check(!mon_active, "R8 closed at pass", mon_active, 0);
    endtask

    task automatic t_reset();
        int n = 0;
        @(negedge clk);
        rst_n = 1'b0;
        div_m1 = 2'd3;
        fir_long = 1'b1;
        repeat (3) @(negedge clk);
        check(mux_state == 3'd4, "R1 reset mux_state", mux_state, 4);
        check({pass_start, conv_done, frame_sync, mon_active, xfer_busy} == 5'd0,
              "R1 reset strobes", {pass_start, conv_done, frame_sync, mon_active, xfer_busy}, 0);
        rst_n = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (!pass_start)
                check(mux_state == 3'd4 && !conv_done && !mon_active, "R1 idle after reset", mux_state, 4);
        end while (!pass_start && n < 1000);
        check(n == CKS, "R1 R2 first pass delay", n, CKS);
        scan_frame(4, 3, -1, 2'd0, 1'b0);
    endtask

    task automatic t_configs();
        int dm [6] = '{3, 0, 0, 1, 2, 3};
        int lg [6] = '{0, 0, 1, 1, 0, 1};
        for (int i = 0; i < 6; i++) begin
            div_m1 = 2'(dm[i]);
            fir_long = lg[i][0];
            wait_pass();
            scan_frame(dm[i] + 1, lg[i] ? 3 : 2, -1, 2'd0, 1'b0);
        end
    endtask

    task automatic t_midchange();
        div_m1 = 2'd1;
        fir_long = 1'b0;
        wait_pass();
        // R9: change during frame, this frame keeps the old setting
        scan_frame(2, 2, 5, 2'd3, 1'b1);
        scan_frame(4, 3, -1, 2'd0, 1'b0);
    endtask

    task automatic t_xfer(input int ps, input int sc, input int passes);
        int period = (ps * sc == 0) ? 1 : ps * sc;
        presamps = 4'(ps);
        sum_cycles = 4'(sc);
        div_m1 = 2'd0;
        fir_long = 1'b0;
        do_reset();
        for (int i = 1; i <= passes; i++) begin
            wait_pass();
            check(xfer_busy == (i % period == 0), "R10 busy at pass", xfer_busy, (i % period == 0));
            repeat (12) @(negedge clk);
            check(xfer_busy == (i % period == 0), "R10 busy mid-frame", xfer_busy, (i % period == 0));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_configs();
        t_midchange();
        t_xfer(1, 3, 7);
        t_xfer(2, 2, 9);
        t_xfer(0, 5, 3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule